// File: doc/BRIEF.md
# Pin Controller with Level and Edge Interrupts

This block is a bank of general-purpose pins behind a 32-bit word-addressed register bus. Software configures each pin through per-pin bit vectors: whether its input is sampled, whether its output is driven, the output value, an inversion applied to that value, a pull-up, and a stored drive-strength and alternate-function selection. The block works out the level each pin actually sits at and samples it into an input value register. From that value it raises four sticky pending flags per pin: level high, level low, rising edge and falling edge.

Each pending register has its own enable register, and each pin has one interrupt line that is asserted while any enabled pending flag of that pin is set. A pin's level comes from the outside world when an external agent drives it, otherwise from the block's own output when that is enabled, and otherwise from its pull-up bit. When the outside and the block drive the same pin at the same time, a per-pin conflict flag is raised. External pin inputs cross into the clock domain through a two-flop synchronizer. Every state update happens on the clock edge. Register writes take effect at the edge that samples them, and the pin logic then evaluates again from the new settings.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: While reset is held, every register reads 0, and `irq`, `short_flag`, `pin_out` and `pin_level` are 0.
- R2: The plain registers read back the written value on the next cycle. Their offsets are: input enable 0x04, output enable 0x08, output value 0x0C, pull-up 0x10, drive strength 0x14, rise enable 0x18, fall enable 0x20, high enable 0x28, low enable 0x30, alternate enable 0x38, alternate select 0x3C, output invert 0x40. Offset 0x00 (input value) is read-only. Reads at any other offset return 0, and writes to other offsets change no register.
- R3: `pin_out[i]` = output-enable AND (output value XOR invert). `pin_level[i]` follows this priority: the synchronized external level when external drive is on; otherwise `pin_out[i]` when the output is enabled; otherwise the pull-up bit.
- R4: A change on `ext_drv_en`/`ext_drv_lvl` shows on `pin_level` after exactly two clock edges.
- R5: The input value register (0x00) holds input-enable AND `pin_level`, captured at each clock edge.
- R6: The pending flags at 0x2C (high) and 0x34 (low) are sticky. The high flag is set at each edge where the sampled input value is 1, and the low flag where it is 0. Because input values are 0 after reset, every low flag is set by the first edge after reset.
- R7: The rise flag (0x1C) is set at an edge where the input value is 1 and the stored value (0x00) is 0. The fall flag (0x24) is set for the opposite change. Both flags are sticky.
- R8: A write to a pending register clears each bit written as 1 and keeps each bit written as 0. A level flag whose condition still holds reads 1 again right after the clearing write.
- R9: `irq[i]` is the OR, over the four kinds, of pending bit AND enable bit. It follows the registers with no added cycle.
- R10: `short_flag[i]` is 1 exactly when the synchronized external drive is on and the output enable of pin i is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled at the clock edge |
| bus_addr | input | 8 | Byte offset of the word accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| ext_drv_en | input | NPINS | External agent drives the pin (asynchronous) |
| ext_drv_lvl | input | NPINS | Level driven by the external agent (asynchronous) |
| pin_out | output | NPINS | Level the block's own output stage drives |
| pin_level | output | NPINS | Resolved pin level |
| irq | output | NPINS | Per-pin interrupt |
| short_flag | output | NPINS | External and internal drive on the same pin |

## Verification
A register write lands at the edge that samples it. `pin_out`, `pin_level`, `short_flag` and `irq` follow from that edge with no further delay. The input value and all pending flags reflect the new settings one edge later. External drive changes reach `pin_level` two edges after they are applied and reach the input value and pending flags three edges after. The bench drives inputs on the falling edge and samples after falling edges. Each check waits the exact number of rising edges its result needs, and a few checks sample one edge early to confirm a result has not yet appeared. The resolution sweep covers all 64 combinations of the six per-pin controls, 32 pins at a time.

// File: rtl/gpio_irq_pkg.sv
// Package gpio_irq_pkg
// Register offsets and widths shared by the pin controller and its bench.
// Assumes a byte-offset bus with word-aligned accesses only.
package gpio_irq_pkg;
    localparam int unsigned BUS_W  = 32;
    localparam int unsigned ADDR_W = 8;
    localparam int unsigned N_KIND = 4;

    // Interrupt kinds, used as index into the pending/enable arrays
    localparam int unsigned K_RISE = 0;
    localparam int unsigned K_FALL = 1;
    localparam int unsigned K_HIGH = 2;
    localparam int unsigned K_LOW  = 3;

    localparam logic [ADDR_W-1:0] OFF_INVAL     = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_IN_EN     = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_OUT_EN    = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_OUT_VAL   = 8'h0C;
    localparam logic [ADDR_W-1:0] OFF_PULL      = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_DRIVE     = 8'h14;
    localparam logic [ADDR_W-1:0] OFF_RISE_EN   = 8'h18;
    localparam logic [ADDR_W-1:0] OFF_RISE_PEND = 8'h1C;
    localparam logic [ADDR_W-1:0] OFF_FALL_EN   = 8'h20;
    localparam logic [ADDR_W-1:0] OFF_FALL_PEND = 8'h24;
    localparam logic [ADDR_W-1:0] OFF_HIGH_EN   = 8'h28;
    localparam logic [ADDR_W-1:0] OFF_HIGH_PEND = 8'h2C;
    localparam logic [ADDR_W-1:0] OFF_LOW_EN    = 8'h30;
    localparam logic [ADDR_W-1:0] OFF_LOW_PEND  = 8'h34;
    localparam logic [ADDR_W-1:0] OFF_ALT_EN    = 8'h38;
    localparam logic [ADDR_W-1:0] OFF_ALT_SEL   = 8'h3C;
    localparam logic [ADDR_W-1:0] OFF_OUT_INV   = 8'h40;
endpackage

// File: rtl/gpio_sync2.sv
// Module gpio_sync2
// Two-flop synchronizer for a vector of asynchronous inputs.
// Assumes each bit is independent (no bus coherency is provided).
module gpio_sync2 #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] stage1;

    // Capture and retime the asynchronous inputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q_sync <= '0;
        end else begin
            stage1 <= d_async;
            q_sync <= stage1;
        end
    end
endmodule

// File: rtl/gpio_cfg_regs.sv
// Module gpio_cfg_regs
// Register file: stores configuration words, decodes pending-clear
// strobes and multiplexes read data. Assumes word-aligned byte offsets;
// an offset that matches no register is ignored on write, reads as 0.
module gpio_cfg_regs
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NPINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    // live state for readback
    input  logic [NPINS-1:0]  in_value,
    input  logic [N_KIND-1:0][NPINS-1:0] pend,
    // configuration out
    output logic [NPINS-1:0]  in_en,
    output logic [NPINS-1:0]  out_en,
    output logic [NPINS-1:0]  out_val,
    output logic [NPINS-1:0]  pull_en,
    output logic [NPINS-1:0]  out_inv,
    output logic [N_KIND-1:0][NPINS-1:0] kind_en,
    output logic [N_KIND-1:0][NPINS-1:0] kind_clr
);
    logic [NPINS-1:0] drive_q;
    logic [NPINS-1:0] alt_en_q;
    logic [NPINS-1:0] alt_sel_q;
    logic [NPINS-1:0] wr_pins;

    assign wr_pins = bus_wdata[NPINS-1:0];

    // Zero-extend a pin vector to bus width
    function automatic logic [BUS_W-1:0] widen(input logic [NPINS-1:0] v);
        logic [BUS_W-1:0] r;
        r = '0;
        r[NPINS-1:0] = v;
        return r;
    endfunction

    // Store the plain configuration words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_en     <= '0;
            out_en    <= '0;
            out_val   <= '0;
            pull_en   <= '0;
            out_inv   <= '0;
            drive_q   <= '0;
            alt_en_q  <= '0;
            alt_sel_q <= '0;
            kind_en   <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                OFF_IN_EN:   in_en            <= wr_pins;
                OFF_OUT_EN:  out_en           <= wr_pins;
                OFF_OUT_VAL: out_val          <= wr_pins;
                OFF_PULL:    pull_en          <= wr_pins;
                OFF_DRIVE:   drive_q          <= wr_pins;
                OFF_RISE_EN: kind_en[K_RISE]  <= wr_pins;
                OFF_FALL_EN: kind_en[K_FALL]  <= wr_pins;
                OFF_HIGH_EN: kind_en[K_HIGH]  <= wr_pins;
                OFF_LOW_EN:  kind_en[K_LOW]   <= wr_pins;
                OFF_ALT_EN:  alt_en_q         <= wr_pins;
                OFF_ALT_SEL: alt_sel_q        <= wr_pins;
                OFF_OUT_INV: out_inv          <= wr_pins;
                default: ;
            endcase
        end
    end

    // Decode write-one-to-clear strobes for the pending words
    always_comb begin
        kind_clr = '0;
        if (bus_wr) begin
            case (bus_addr)
                OFF_RISE_PEND: kind_clr[K_RISE] = wr_pins;
                OFF_FALL_PEND: kind_clr[K_FALL] = wr_pins;
                OFF_HIGH_PEND: kind_clr[K_HIGH] = wr_pins;
                OFF_LOW_PEND:  kind_clr[K_LOW]  = wr_pins;
                default: ;
            endcase
        end
    end

    // Read multiplexer
    always_comb begin
        case (bus_addr)
            OFF_INVAL:     bus_rdata = widen(in_value);
            OFF_IN_EN:     bus_rdata = widen(in_en);
            OFF_OUT_EN:    bus_rdata = widen(out_en);
            OFF_OUT_VAL:   bus_rdata = widen(out_val);
            OFF_PULL:      bus_rdata = widen(pull_en);
            OFF_DRIVE:     bus_rdata = widen(drive_q);
            OFF_RISE_EN:   bus_rdata = widen(kind_en[K_RISE]);
            OFF_RISE_PEND: bus_rdata = widen(pend[K_RISE]);
            OFF_FALL_EN:   bus_rdata = widen(kind_en[K_FALL]);
            OFF_FALL_PEND: bus_rdata = widen(pend[K_FALL]);
            OFF_HIGH_EN:   bus_rdata = widen(kind_en[K_HIGH]);
            OFF_HIGH_PEND: bus_rdata = widen(pend[K_HIGH]);
            OFF_LOW_EN:    bus_rdata = widen(kind_en[K_LOW]);
            OFF_LOW_PEND:  bus_rdata = widen(pend[K_LOW]);
            OFF_ALT_EN:    bus_rdata = widen(alt_en_q);
            OFF_ALT_SEL:   bus_rdata = widen(alt_sel_q);
            OFF_OUT_INV:   bus_rdata = widen(out_inv);
            default:       bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_pin_resolve.sv
// Module gpio_pin_resolve
// Per-pin combinational resolution: output stage, three-way level
// priority (external, own output, pull-up), input gating and drive
// conflict. Assumes external inputs are already synchronized.
module gpio_pin_resolve #(
    parameter int unsigned NPINS = 32
) (
    input  logic [NPINS-1:0] ext_en,
    input  logic [NPINS-1:0] ext_lvl,
    input  logic [NPINS-1:0] in_en,
    input  logic [NPINS-1:0] out_en,
    input  logic [NPINS-1:0] out_val,
    input  logic [NPINS-1:0] out_inv,
    input  logic [NPINS-1:0] pull_en,
    output logic [NPINS-1:0] drive_val,
    output logic [NPINS-1:0] level,
    output logic [NPINS-1:0] in_val,
    output logic [NPINS-1:0] conflict
);
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        // Resolve one pin
        always_comb begin
            drive_val[i] = out_en[i] & (out_val[i] ^ out_inv[i]);
            if (ext_en[i])
                level[i] = ext_lvl[i];
            else if (out_en[i])
                level[i] = drive_val[i];
            else
                level[i] = pull_en[i];
            in_val[i]   = in_en[i] & level[i];
            conflict[i] = ext_en[i] & out_en[i];
        end
    end
endmodule

// File: rtl/gpio_pend_irq.sv
// Module gpio_pend_irq
// Holds the sampled input value and the four sticky pending words,
// applies write-one-to-clear strobes, and combines enabled pending bits
// into one interrupt per pin. A clear and a set in the same cycle leave
// the bit set, so held level conditions re-arm at once.
module gpio_pend_irq
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NPINS = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NPINS-1:0]             in_val,
    input  logic [N_KIND-1:0][NPINS-1:0] kind_en,
    input  logic [N_KIND-1:0][NPINS-1:0] kind_clr,
    output logic [NPINS-1:0]             value_q,
    output logic [N_KIND-1:0][NPINS-1:0] pend,
    output logic [NPINS-1:0]             irq
);
    logic [N_KIND-1:0][NPINS-1:0] cond;
    logic [N_KIND-1:0][NPINS-1:0] gated;

    // Event conditions against the stored previous sample
    always_comb begin
        cond[K_RISE] = in_val & ~value_q;
        cond[K_FALL] = ~in_val & value_q;
        cond[K_HIGH] = in_val;
        cond[K_LOW]  = ~in_val;
    end

    // Previous-sample register
    always_ff @(posedge clk) begin
        if (!rst_n) value_q <= '0;
        else        value_q <= in_val;
    end

    for (genvar k = 0; k < N_KIND; k++) begin : g_kind
        // Sticky pending word for one kind
        always_ff @(posedge clk) begin
            if (!rst_n) pend[k] <= '0;
            else        pend[k] <= (pend[k] & ~kind_clr[k]) | cond[k];
        end
        assign gated[k] = pend[k] & kind_en[k];
    end

    // OR the enabled pending bits of all kinds
    always_comb begin
        irq = '0;
        for (int k = 0; k < N_KIND; k++) irq = irq | gated[k];
    end
endmodule

// File: rtl/gpio_irq_ctrl.sv
// Module gpio_irq_ctrl
// Top of the pin controller: synchronizer, register file, pin
// resolution and pending/interrupt logic. Assumes NPINS <= 32 and a
// single clock domain for the bus.
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NPINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  ext_drv_en,
    input  logic [NPINS-1:0]  ext_drv_lvl,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_level,
    output logic [NPINS-1:0]  irq,
    output logic [NPINS-1:0]  short_flag
);
    logic [NPINS-1:0] sync_en, sync_lvl;
    logic [NPINS-1:0] in_en, out_en, out_val, pull_en, out_inv;
    logic [NPINS-1:0] in_val, value_q;
    logic [N_KIND-1:0][NPINS-1:0] kind_en, kind_clr, pend;

    gpio_sync2 #(.W(2*NPINS)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({ext_drv_en, ext_drv_lvl}),
        .q_sync  ({sync_en, sync_lvl})
    );

    gpio_cfg_regs #(.NPINS(NPINS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .in_value  (value_q),
        .pend      (pend),
        .in_en     (in_en),
        .out_en    (out_en),
        .out_val   (out_val),
        .pull_en   (pull_en),
        .out_inv   (out_inv),
        .kind_en   (kind_en),
        .kind_clr  (kind_clr)
    );

    gpio_pin_resolve #(.NPINS(NPINS)) u_pins (
        .ext_en    (sync_en),
        .ext_lvl   (sync_lvl),
        .in_en     (in_en),
        .out_en    (out_en),
        .out_val   (out_val),
        .out_inv   (out_inv),
        .pull_en   (pull_en),
        .drive_val (pin_out),
        .level     (pin_level),
        .in_val    (in_val),
        .conflict  (short_flag)
    );

    gpio_pend_irq #(.NPINS(NPINS)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_val   (in_val),
        .kind_en  (kind_en),
        .kind_clr (kind_clr),
        .value_q  (value_q),
        .pend     (pend),
        .irq      (irq)
    );
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
// Module gpio_irq_ctrl_chk
// Property checker for gpio_irq_ctrl, attached with bind below.
// Assumes the synchronous active-low reset is low at time zero.
module gpio_irq_ctrl_chk #(
    parameter int unsigned NPINS = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NPINS-1:0] irq,
    input logic [NPINS-1:0] short_flag,
    input logic [NPINS-1:0] pin_level,
    input logic [NPINS-1:0] sync_lvl,
    input logic [NPINS-1:0] value_q,
    input logic [NPINS-1:0] rise_p,
    input logic [NPINS-1:0] high_p,
    input logic [NPINS-1:0] clr_high,
    input logic [NPINS-1:0] any_en
);
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (irq == '0 && short_flag == '0)); // R1

    AST_EXT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_level ^ sync_lvl) & short_flag) == '0); // R3

    AST_HIGH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(high_p) & ~$past(clr_high)) & ~high_p) == '0)); // R6

    AST_RISE_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((value_q & ~$past(value_q)) & ~rise_p) == '0)); // R7

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (irq & ~any_en) == '0); // R9
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NPINS(NPINS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq        (irq),
    .short_flag (short_flag),
    .pin_level  (pin_level),
    .sync_lvl   (sync_lvl),
    .value_q    (value_q),
    .rise_p     (pend[0]),
    .high_p     (pend[2]),
    .clr_high   (kind_clr[2]),
    .any_en     (kind_en[0] | kind_en[1] | kind_en[2] | kind_en[3])
);

// File: tb/tb_gpio_irq_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_irq_ctrl;
    import gpio_irq_pkg::*;
    localparam int unsigned NP = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] ext_drv_en = '0;
    logic [NP-1:0] ext_drv_lvl = '0;
    logic [NP-1:0] pin_out, pin_level, irq, short_flag;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 0;

    always #4 clk = ~clk;

    gpio_irq_ctrl #(.NPINS(NP)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ext_drv_en(ext_drv_en), .ext_drv_lvl(ext_drv_lvl),
        .pin_out(pin_out), .pin_level(pin_level), .irq(irq),
        .short_flag(short_flag)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_cfg();
        wr(OFF_OUT_EN, 0); wr(OFF_OUT_VAL, 0); wr(OFF_OUT_INV, 0);
        wr(OFF_PULL, 0); wr(OFF_IN_EN, 0);
        wr(OFF_RISE_EN, 0); wr(OFF_FALL_EN, 0);
        wr(OFF_HIGH_EN, 0); wr(OFF_LOW_EN, 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] r, e, p_old, p_new, rise_e, fall_e;
        logic [7:0] offs [17];
        logic [7:0] plain [12];
        offs = '{8'h00,8'h04,8'h08,8'h0C,8'h10,8'h14,8'h18,8'h1C,8'h20,
                 8'h24,8'h28,8'h2C,8'h30,8'h34,8'h38,8'h3C,8'h40};
        plain = '{8'h04,8'h08,8'h0C,8'h10,8'h14,8'h18,8'h20,8'h28,8'h30,
                  8'h38,8'h3C,8'h40};

        // R1: state while reset is held
        idle(3);
        for (int i = 0; i < 17; i++) begin
            rd(offs[i], r);
            chk($sformatf("R1 reg %h in reset", offs[i]), r, 0);
        end
        chk("R1 irq in reset", irq, 0);
        chk("R1 short in reset", short_flag, 0);
        chk("R1 pin_out in reset", pin_out, 0);
        chk("R1 pin_level in reset", pin_level, 0);
        @(negedge clk); rst_n = 1'b1;
        idle(1);
        // R6: input disabled means value 0, so low flags all set after first edge
        rd(OFF_LOW_PEND, r);
        chk("R6 low pending after reset", r, 32'hFFFF_FFFF);
        rd(OFF_HIGH_PEND, r);
        chk("R6 high pending after reset", r, 0);

        // R2: readback of every plain register, then clear it
        for (int i = 0; i < 12; i++) begin
            e = 32'hA5C3_0F00 ^ (32'h0101_0101 * (i + 1));
            wr(plain[i], e);
            rd(plain[i], r);
            chk($sformatf("R2 readback %h", plain[i]), r, e);
            wr(plain[i], 0);
        end
        // R2: read-only value word and unmapped offsets
        wr(OFF_INVAL, 32'hFFFF_FFFF);
        rd(OFF_INVAL, r);
        chk("R2 value word ignores write", r, 0);
        wr(8'h44, 32'h1234_5678);
        wr(8'h80, 32'hFFFF_FFFF);
        rd(8'h44, r);  chk("R2 unmapped 0x44 reads 0", r, 0);
        rd(8'h80, r);  chk("R2 unmapped 0x80 reads 0", r, 0);
        for (int i = 0; i < 12; i++) begin
            rd(plain[i], r);
            chk($sformatf("R2 unmapped write left %h", plain[i]), r, 0);
        end

        // R3 R5 R10: exhaustive sweep of six per-pin controls, two passes of 32
        for (int p = 0; p < 2; p++) begin
            logic [31:0] v_een, v_elv, v_oe, v_pv, v_inv, v_pu, e_lvl, e_out, e_sh;
            for (int i = 0; i < 32; i++) begin
                int c;
                c = i + 32 * p;
                v_een[i] = c[0]; v_elv[i] = c[1]; v_oe[i] = c[2];
                v_pv[i] = c[3]; v_inv[i] = c[4]; v_pu[i] = c[5];
                e_out[i] = v_oe[i] & (v_pv[i] ^ v_inv[i]);
                e_lvl[i] = v_een[i] ? v_elv[i] : (v_oe[i] ? e_out[i] : v_pu[i]);
                e_sh[i]  = v_een[i] & v_oe[i];
            end
            wr(OFF_OUT_EN, v_oe); wr(OFF_OUT_VAL, v_pv);
            wr(OFF_OUT_INV, v_inv); wr(OFF_PULL, v_pu);
            wr(OFF_IN_EN, 32'hFFFF_FFFF);
            @(negedge clk); ext_drv_en = v_een; ext_drv_lvl = v_elv;
            idle(4);
            chk($sformatf("R3 pin_out pass %0d", p), pin_out, e_out);
            chk($sformatf("R3 pin_level pass %0d", p), pin_level, e_lvl);
            chk($sformatf("R10 short pass %0d", p), short_flag, e_sh);
            rd(OFF_INVAL, r);
            chk($sformatf("R5 value all enabled pass %0d", p), r, e_lvl);
            wr(OFF_IN_EN, 32'h5555_5555);
            idle(1);
            rd(OFF_INVAL, r);
            chk($sformatf("R5 value gated pass %0d", p), r, e_lvl & 32'h5555_5555);
        end

        // R4: synchronizer latency on pin 3
        @(negedge clk); ext_drv_en = '0; ext_drv_lvl = '0;
        clear_cfg();
        wr(OFF_IN_EN, 32'hFFFF_FFFF);
        idle(3);
        chk("R4 level before ext drive", pin_level, 0);
        ext_drv_en = 32'h8; ext_drv_lvl = 32'h8;
        idle(1);
        chk("R4 level after one edge", pin_level, 0);
        idle(1);
        chk("R4 level after two edges", pin_level, 32'h8);
        idle(1);
        rd(OFF_INVAL, r);
        chk("R5 value one edge after level", r, 32'h8);
        ext_drv_en = '0; ext_drv_lvl = '0;

        // R7: edges from the own output, all pins input-enabled
        wr(OFF_OUT_EN, 32'hFFFF_FFFF);
        idle(4);
        wr(OFF_RISE_PEND, 32'hFFFF_FFFF);
        wr(OFF_FALL_PEND, 32'hFFFF_FFFF);
        rd(OFF_RISE_PEND, r); chk("R8 rise cleared", r, 0);
        rd(OFF_FALL_PEND, r); chk("R8 fall cleared", r, 0);
        p_old = 0; rise_e = 0; fall_e = 0;
        for (int s = 0; s < 3; s++) begin
            p_new = (s == 0) ? 32'hF0F0_F0F0 : (s == 1) ? 32'h0FF0_0FF0 : 32'h0000_FFFF;
            wr(OFF_OUT_VAL, p_new);
            idle(1);
            rise_e = rise_e | (p_new & ~p_old);
            fall_e = fall_e | (~p_new & p_old);
            rd(OFF_RISE_PEND, r); chk($sformatf("R7 rise step %0d", s), r, rise_e);
            rd(OFF_FALL_PEND, r); chk($sformatf("R7 fall step %0d", s), r, fall_e);
            p_old = p_new;
        end

        // R6 R8: level flags re-arm immediately, edge flags clear selectively
        wr(OFF_HIGH_PEND, 32'hFFFF_FFFF);
        rd(OFF_HIGH_PEND, r); chk("R8 high re-set while held", r, p_old);
        wr(OFF_LOW_PEND, 32'hFFFF_FFFF);
        rd(OFF_LOW_PEND, r); chk("R8 low re-set while held", r, ~p_old);
        wr(OFF_FALL_PEND, 32'hF000_0000);
        rd(OFF_FALL_PEND, r); chk("R8 partial clear of fall", r, fall_e & ~32'hF000_0000);
        wr(OFF_RISE_PEND, 32'h0000_0000);
        rd(OFF_RISE_PEND, r); chk("R8 zero write keeps rise", r, rise_e);

        // R9: interrupt combining
        wr(OFF_RISE_PEND, 32'hFFFF_FFFF);
        wr(OFF_FALL_PEND, 32'hFFFF_FFFF);
        chk("R9 no enables no irq", irq, 0);
        wr(OFF_HIGH_EN, 32'h0000_00FF);
        chk("R9 high enable", irq, p_old & 32'hFF);
        wr(OFF_LOW_EN, 32'hFF00_0000);
        chk("R9 high and low", irq, (p_old & 32'hFF) | (~p_old & 32'hFF00_0000));
        wr(OFF_HIGH_EN, 0); wr(OFF_LOW_EN, 0);
        wr(OFF_RISE_EN, 32'hFFFF_FFFF);
        chk("R9 rise enabled nothing pending", irq, 0);
        p_new = 32'h00FF_00FF;
        wr(OFF_OUT_VAL, p_new);
        chk("R9 rise not yet sampled", irq, 0);
        idle(1);
        chk("R9 rise irq", irq, p_new & ~p_old);
        wr(OFF_RISE_EN, 0);
        chk("R9 rise disabled", irq, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule